// File: doc/BRIEF.md
# I2C Slave Address Recognition and Acknowledge Control

This block is the slave-side front end of a two-wire serial interface. It watches the clock and data lines and recognises the bus conditions that open and close a transfer. It collects the first byte after each opening condition and compares the seven address bits of that byte with a programmed own address. When the address matches, it acknowledges the byte, selects receive or transmit operation from the direction bit, and raises an interrupt flag together with a status code for the controlling processor.

Both lines pass through a synchroniser before any logic uses them. Bit 0 of the own-address input enables replies to the general call address. A single acknowledge-enable input controls two things. It decides whether the block reacts to its own address, and in receive mode it decides whether the next data byte gets ACK or NACK. An arbitration-lost pulse from a master section makes the block treat the byte in progress as an address byte.

Top module: `i2c_slave_addr_ctrl`

## Requirements
- R1: After reset, `sda_drive_o` is 0, `irq_o` is 0, `status_o` is F8h, `mode_o` is 00 and `rx_data_o` is 0.
- R2: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) restarts the bit count. The next eight SCL rising edges, MSB first, form a fresh address byte, even if a byte was broken off part way.
- R3: The line is pulled low (`sda_drive_o` = 1) only after SCL has fallen. For an acknowledged byte it is low during the ninth SCL high phase, and it is released after the ninth falling edge.
- R4: A byte whose upper seven bits equal `own_addr_i[7:1]` is acknowledged. With bit 0 = 0 the status is 60h and `mode_o` = 01 (slave receive). With bit 0 = 1 the status is A8h and `mode_o` = 10 (slave transmit).
- R5: The byte 00h (general call) is acknowledged only when `own_addr_i[0]` = 1, giving status 70h and `mode_o` = 01. Byte 01h is never acknowledged as a general call.
- R6: Any other address byte gets no ACK, no interrupt and no status change, and `mode_o` stays 00 until the next START.
- R7: While `ack_en_i` = 0, the own address and the general call are both ignored (no ACK, no interrupt). Bus conditions are still tracked, so once the bit is set again the next address byte is recognised.
- R8: In receive mode each data byte is copied to `rx_data_o`. With `ack_en_i` = 1 it is acknowledged with status 80h. With `ack_en_i` = 0 it gets NACK with status 88h, `mode_o` goes to 00, and later bytes are ignored.
- R9: A STOP or repeated START while `mode_o` is 01 or 10 posts status A0h with an interrupt and returns `mode_o` to 00. After a repeated START the next byte is an address byte.
- R10: Each status post sets `irq_o`. `irq_clr_i` clears it, and a post in the same cycle as a clear takes priority.
- R11: While `en_i` = 0 the line is never pulled low, `mode_o` is 00 and no status is posted.
- R12: A pulse on `arb_lost_i` while not addressed makes the byte in progress count as an address byte, even after an earlier address in the same transfer did not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| ack_en_i | input | 1 | Acknowledge enable; gates address recognition and data ACK |
| own_addr_i | input | 8 | [7:1] own slave address, [0] general call enable |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| arb_lost_i | input | 1 | Pulse: master lost arbitration, listen as slave |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| sda_drive_o | output | 1 | 1 = pull data line low |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Last posted status code |
| mode_o | output | 2 | 00 not addressed, 01 slave receive, 10 slave transmit |
| rx_data_o | output | 8 | Last received data byte |

## Verification
The ACK/NACK decision, the status code, the interrupt and the mode change are all due about three clocks after the eighth SCL falling edge: two synchroniser stages plus one output register. The release of the line is due about three clocks after the ninth falling edge. A START or STOP takes effect about three clocks after its SDA edge. The bench holds each SCL phase for eight clocks. It samples the acknowledge, status, interrupt and mode in the middle of the ninth high phase, the release one half period after the ninth fall, and the STOP result one half period after SDA rises, so every sample lands well after the result is due and before the next bus event.

// File: rtl/i2c_sa_pkg.sv
package i2c_sa_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RX, PH_TX} phase_t;

  localparam logic [1:0] MODE_NONE = 2'b00;
  localparam logic [1:0] MODE_RX   = 2'b01;
  localparam logic [1:0] MODE_TX   = 2'b10;

  localparam logic [7:0] ST_OWN_W   = 8'h60;
  localparam logic [7:0] ST_GCALL   = 8'h70;
  localparam logic [7:0] ST_RX_ACK  = 8'h80;
  localparam logic [7:0] ST_RX_NACK = 8'h88;
  localparam logic [7:0] ST_STOP    = 8'hA0;
  localparam logic [7:0] ST_OWN_R   = 8'hA8;
  localparam logic [7:0] ST_NONE    = 8'hF8;
endpackage

// File: rtl/i2c_sa_line_cond.sv
// Synchronises both bus lines and flags edges and bus conditions (R2).
module i2c_sa_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sa_byte_shift.sv
// Collects one byte MSB first, then marks the acknowledge slot.
module i2c_sa_byte_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic [DATA_W-1:0] shift_q,
  output logic              byte_done,
  output logic              ack_end,
  output logic              in_ack
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt;

  assign byte_done = scl_fall && !in_ack && (cnt == FULL);
  assign ack_end   = scl_fall && in_ack;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      in_ack  <= 1'b0;
      shift_q <= '0;
    end else if (scl_rise && !in_ack && cnt != FULL) begin
      shift_q <= {shift_q[DATA_W-2:0], sda_s};
      cnt     <= cnt + 1'b1;
    end else if (byte_done) begin
      in_ack <= 1'b1;
    end else if (ack_end) begin
      in_ack <= 1'b0;
      cnt    <= '0;
    end
  end
endmodule

// File: rtl/i2c_sa_addr_match.sv
// Compares a received byte with the own address and the general call.
module i2c_sa_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0] byte_i,
  input  logic [ADDR_W:0] own_i,
  output logic            hit_own,
  output logic            hit_gc,
  output logic            dir
);
  logic field_zero;

  assign field_zero = (byte_i[ADDR_W:1] == '0);
  assign dir        = byte_i[0];
  assign hit_own    = !field_zero && (byte_i[ADDR_W:1] == own_i[ADDR_W:1]);
  assign hit_gc     = field_zero && own_i[0] && !byte_i[0];
endmodule

// File: rtl/i2c_slave_addr_ctrl.sv
module i2c_slave_addr_ctrl
  import i2c_sa_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              ack_en_i,
  input  logic [ADDR_W:0]   own_addr_i,
  input  logic              irq_clr_i,
  input  logic              arb_lost_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_o,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic [1:0]        mode_o,
  output logic [ADDR_W:0]   rx_data_o
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] shift_q;
  logic byte_done, ack_end, in_ack;
  logic hit_own, hit_gc, dir;

  i2c_sa_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_sa_byte_shift #(.DATA_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clr(start_det | stop_det | ~en_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .shift_q(shift_q), .byte_done(byte_done), .ack_end(ack_end), .in_ack(in_ack)
  );

  i2c_sa_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .byte_i(shift_q), .own_i(own_addr_i),
    .hit_own(hit_own), .hit_gc(hit_gc), .dir(dir)
  );

  phase_t            phase_q, phase_n, eff_phase;
  logic              drive_n, post, addressed;
  logic [7:0]        status_n;
  logic [1:0]        mode_n;
  logic [BYTE_W-1:0] rx_n;

  assign addressed = (phase_q == PH_RX) || (phase_q == PH_TX);
  assign eff_phase = (arb_lost_i && !addressed) ? PH_ADDR : phase_q;

  always_comb begin
    phase_n  = eff_phase;
    drive_n  = sda_drive_o;
    mode_n   = mode_o;
    status_n = status_o;
    rx_n     = rx_data_o;
    post     = 1'b0;
    if (!en_i) begin
      phase_n = PH_IDLE;
      drive_n = 1'b0;
      mode_n  = MODE_NONE;
    end else if (start_det || stop_det) begin
      if (addressed) begin
        post     = 1'b1;
        status_n = ST_STOP;
      end
      phase_n = start_det ? PH_ADDR : PH_IDLE;
      drive_n = 1'b0;
      mode_n  = MODE_NONE;
    end else begin
      if (byte_done) begin
        case (eff_phase)
          PH_ADDR: begin
            if (ack_en_i && hit_own && !dir) begin
              drive_n = 1'b1; phase_n = PH_RX; mode_n = MODE_RX;
              post = 1'b1; status_n = ST_OWN_W;
            end else if (ack_en_i && hit_own && dir) begin
              drive_n = 1'b1; phase_n = PH_TX; mode_n = MODE_TX;
              post = 1'b1; status_n = ST_OWN_R;
            end else if (ack_en_i && hit_gc) begin
              drive_n = 1'b1; phase_n = PH_RX; mode_n = MODE_RX;
              post = 1'b1; status_n = ST_GCALL;
            end else begin
              phase_n = PH_IDLE;
            end
          end
          PH_RX: begin
            rx_n = shift_q;
            post = 1'b1;
            if (ack_en_i) begin
              drive_n  = 1'b1;
              status_n = ST_RX_ACK;
            end else begin
              drive_n  = 1'b0;
              status_n = ST_RX_NACK;
              phase_n  = PH_IDLE;
              mode_n   = MODE_NONE;
            end
          end
          default: ;
        endcase
      end
      if (ack_end) drive_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      sda_drive_o <= 1'b0;
      irq_o       <= 1'b0;
      status_o    <= ST_NONE;
      mode_o      <= MODE_NONE;
      rx_data_o   <= '0;
    end else begin
      phase_q     <= phase_n;
      sda_drive_o <= drive_n;
      irq_o       <= post | (irq_o & ~irq_clr_i);
      status_o    <= status_n;
      mode_o      <= mode_n;
      rx_data_o   <= rx_n;
    end
  end
endmodule

// File: rtl/i2c_sa_checker.sv
module i2c_sa_checker (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       ack_en_i,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_drive_o,
  input logic       irq_o,
  input logic [7:0] status_o,
  input logic [1:0] mode_o
);
  a_r3_drive_on_low_scl: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_o) |-> !$past(scl_s));

  a_r7_drive_needs_ack_en: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_o) |-> ($past(ack_en_i) && $past(en_i)));

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!sda_drive_o && mode_o == 2'b00));

  a_r9_stop_clears_mode: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (mode_o == 2'b00));

  a_r10_irq_status_legal: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (status_o == 8'h60 || status_o == 8'h70 || status_o == 8'h80 ||
                      status_o == 8'h88 || status_o == 8'hA0 || status_o == 8'hA8));

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b11);
endmodule

bind i2c_slave_addr_ctrl i2c_sa_checker u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .ack_en_i(ack_en_i), .scl_s(scl_s),
  .stop_det(stop_det), .sda_drive_o(sda_drive_o), .irq_o(irq_o),
  .status_o(status_o), .mode_o(mode_o)
);

// File: tb/i2c_slave_addr_ctrl_tb.sv
module i2c_slave_addr_ctrl_tb_top;
  localparam int HP = 8;
  localparam logic [7:0] OWN_W = 8'h5A;
  localparam logic [7:0] OWN_R = 8'h5B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, ack_en = 1'b1, irq_clr = 1'b0, arb_lost = 1'b0;
  logic [7:0] own = 8'h5B;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_drive, irq;
  logic [7:0] status, rx_data;
  logic [1:0] mode;
  wire sda_bus = sda_m & ~sda_drive;

  int n_chk = 0, n_fail = 0;
  bit timeout = 0;

  always #10 clk = ~clk;

  i2c_slave_addr_ctrl dut_i (
    .clk(clk), .rst(rst), .en_i(en), .ack_en_i(ack_en), .own_addr_i(own),
    .irq_clr_i(irq_clr), .arb_lost_i(arb_lost), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_o(sda_drive), .irq_o(irq), .status_o(status), .mode_o(mode),
    .rx_data_o(rx_data)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; w(1); irq_clr = 1'b0; w(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; w(HP); sda_m = 1'b0; w(HP); scl_m = 1'b0; w(HP);
  endtask

  task automatic bus_rstart();
    w(2); sda_m = 1'b1; w(HP); scl_m = 1'b1; w(HP); sda_m = 1'b0; w(HP); scl_m = 1'b0; w(HP);
  endtask

  task automatic bus_stop();
    w(2); sda_m = 1'b0; w(HP); scl_m = 1'b1; w(HP); sda_m = 1'b1; w(HP);
  endtask

  task automatic send_bit(input logic b);
    w(2); sda_m = b; w(HP); scl_m = 1'b1; w(HP); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic irqv,
                           output logic [7:0] st, output logic [1:0] md);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(2); sda_m = 1'b1; w(HP); scl_m = 1'b1; w(HP/2);
    ack = ~sda_bus; irqv = irq; st = status; md = mode;
    w(HP/2); scl_m = 1'b0; w(HP);
    chk("R3 released after ninth fall", sda_drive, 1'b0);
  endtask

  task automatic run_all();
    logic ack, iv;
    logic [7:0] st;
    logic [1:0] md;
    // R1 reset state
    w(3);
    chk("R1 drive", sda_drive, 0); chk("R1 irq", irq, 0); chk("R1 status", status, 8'hF8);
    chk("R1 mode", mode, 0); chk("R1 rx_data", rx_data, 0);
    rst = 1'b0; w(4);

    // R4 R5 R6 sweep of every address byte with general call enabled
    for (int b = 0; b < 256; b++) begin
      logic exp_ack;
      logic [1:0] exp_md;
      logic [7:0] exp_st;
      exp_ack = 1'b0; exp_md = 2'b00; exp_st = 8'h00;
      if (b[7:1] == 7'h2D) begin
        exp_ack = 1'b1; exp_md = b[0] ? 2'b10 : 2'b01; exp_st = b[0] ? 8'hA8 : 8'h60;
      end else if (b == 0) begin
        exp_ack = 1'b1; exp_md = 2'b01; exp_st = 8'h70;
      end
      clr_irq();
      bus_start();
      send_byte(8'(b), ack, iv, st, md);
      chk("R4/R5/R6 ack", ack, exp_ack);
      chk("R10 irq on address", iv, exp_ack);
      chk("R4/R5/R6 mode", md, exp_md);
      if (exp_ack) chk("R4/R5 status", st, exp_st);
      bus_stop();
      chk("R9 stop mode", mode, 0);
      chk("R9 stop irq", irq, exp_ack);
      if (exp_ack) chk("R9 stop status", status, 8'hA0);
    end

    // R10 clear
    clr_irq();
    chk("R10 clear", irq, 0);

    // R5 general call disabled
    own = 8'h5A;
    bus_start(); send_byte(8'h00, ack, iv, st, md);
    chk("R5 gc disabled ack", ack, 0); chk("R5 gc disabled irq", iv, 0);
    chk("R5 gc disabled mode", md, 0);
    bus_stop();
    own = 8'h5B;

    // R8 receive data, ACK then NACK
    bus_start(); send_byte(OWN_W, ack, iv, st, md);
    chk("R4 own W ack", ack, 1);
    clr_irq();
    send_byte(8'hC3, ack, iv, st, md);
    chk("R8 data ack", ack, 1); chk("R8 status 80", st, 8'h80);
    chk("R8 rx_data", rx_data, 8'hC3); chk("R10 data irq", iv, 1);
    clr_irq();
    ack_en = 1'b0;
    send_byte(8'h3C, ack, iv, st, md);
    chk("R8 data nack", ack, 0); chk("R8 status 88", st, 8'h88);
    chk("R8 rx_data nack", rx_data, 8'h3C); chk("R8 mode after nack", md, 0);
    ack_en = 1'b1;
    clr_irq();
    send_byte(8'h55, ack, iv, st, md);
    chk("R8 later byte ignored ack", ack, 0); chk("R8 later byte rx_data", rx_data, 8'h3C);
    chk("R8 later byte irq", iv, 0);
    bus_stop();
    chk("R8 stop not addressed irq", irq, 0);

    // R7 ack_en clear ignores own address and general call, then resumes
    ack_en = 1'b0;
    bus_start(); send_byte(OWN_W, ack, iv, st, md);
    chk("R7 own ignored ack", ack, 0); chk("R7 own ignored irq", iv, 0);
    bus_rstart(); send_byte(8'h00, ack, iv, st, md);
    chk("R7 gc ignored ack", ack, 0); chk("R7 gc ignored mode", md, 0);
    ack_en = 1'b1;
    bus_rstart(); send_byte(OWN_W, ack, iv, st, md);
    chk("R7 resumed ack", ack, 1); chk("R7 resumed status", st, 8'h60);

    // R9 repeated start while addressed, then transmit mode
    clr_irq();
    bus_rstart();
    chk("R9 rstart status", status, 8'hA0); chk("R9 rstart irq", irq, 1);
    chk("R9 rstart mode", mode, 0);
    send_byte(OWN_R, ack, iv, st, md);
    chk("R4 own R ack", ack, 1); chk("R4 own R mode", md, 2'b10);
    send_byte(8'hFF, ack, iv, st, md);
    chk("R4 tx byte not driven", ack, 0); chk("R4 tx mode held", md, 2'b10);
    clr_irq();
    bus_stop();
    chk("R9 stop from tx status", status, 8'hA0); chk("R9 stop from tx irq", irq, 1);

    // R2 broken byte followed by repeated start, and by stop
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_rstart(); send_byte(OWN_W, ack, iv, st, md);
    chk("R2 restart after partial byte", ack, 1);
    bus_stop();
    bus_start(); send_bit(1'b0); send_bit(1'b1);
    bus_stop(); bus_start(); send_byte(OWN_R, ack, iv, st, md);
    chk("R2 stop after partial byte", ack, 1); chk("R2 mode", md, 2'b10);
    bus_stop();

    // R11 disabled
    en = 1'b0; clr_irq();
    bus_start(); send_byte(OWN_W, ack, iv, st, md);
    chk("R11 no ack", ack, 0); chk("R11 no irq", iv, 0); chk("R11 mode", md, 0);
    bus_stop();
    en = 1'b1;

    // R12 arbitration lost
    bus_start(); send_byte(8'h10, ack, iv, st, md);
    chk("R6 mismatch", ack, 0);
    send_byte(OWN_W, ack, iv, st, md);
    chk("R12 no arb_lost: second byte ignored", ack, 0);
    w(1); arb_lost = 1'b1; w(1); arb_lost = 1'b0;
    send_byte(OWN_W, ack, iv, st, md);
    chk("R12 arb_lost ack", ack, 1); chk("R12 arb_lost status", st, 8'h60);
    chk("R12 arb_lost mode", md, 2'b01);
    bus_stop();
  endtask

  initial begin
    fork
      run_all();
      begin repeat (190000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule